// File: doc/BRIEF.md
# Per-CPU Level Interrupt Aggregator

This block gathers a set of level-sensitive peripheral interrupt lines and drives one interrupt line toward each CPU. Every CPU owns a private bank of registers: live status words, mask words that read back the current mask state, and a pair of write-one word groups. One group masks inputs and the other unmasks them, so software never needs a read-modify-write to change a single enable. Each input can therefore be steered to any subset of the CPUs.

The inputs come in groups of 32, with two to five groups (64 to 160 lines). There is no priority encoder, vector or queue. A CPU that sees its line high reads every status word and every mask word and finds the pending sources itself. The block holds no edge or polarity state. Status is simply the present input level, and a source that drops its line also drops its share of the CPU line.

Registers sit behind a word-addressed port that completes in one cycle. The upper address bits pick the CPU bank and the lower bits pick a word inside it. Read data is registered and shows the word addressed in the previous cycle.

Top module: `irq_l1_aggregator`

## Requirements
- R1: While reset is held and in the cycle after it is released, every mask bit of every CPU bank is 1 and every irq_out bit is 0, whatever irq_in is.
- R2: In each bank, the read at offset k (0 <= k < W, W = NUM_IRQ/32) returns irq_in[32k+31:32k]. Bit b of that word is input 32k+b. bus_rdata shows the word addressed at the previous clock edge.
- R3: In each bank, the read at offset W+k returns that bank's mask word k. A 1 means the input is masked.
- R4: A write at offset 2W+k sets the bank's mask bits wherever bus_wdata holds a 1. Bits where bus_wdata is 0 keep their value.
- R5: A write at offset 3W+k clears the bank's mask bits wherever bus_wdata holds a 1. Bits where bus_wdata is 0 keep their value.
- R6: The set and clear words (offsets 2W..4W-1) read as zero. Writes to the status and mask words (offsets 0..2W-1) change no mask bit.
- R7: irq_out[c] is registered. After a clock edge it equals the OR over all inputs of (irq_in AND NOT mask of bank c) sampled at that edge. A change in an input or a mask bit therefore shows one cycle later.
- R8: The bank is selected by bus_addr[ADDR_W-1:OFF_W] and the offset by bus_addr[OFF_W-1:0], where OFF_W = clog2(4W). A write to one bank never alters another bank's mask.
- R9: Inputs are not latched. When an unmasked input falls and no other unmasked input of that bank is high, irq_out[c] falls one cycle later.
- R10: Offsets 4W and above, and bank indices NUM_CPU and above, read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_in | input | NUM_IRQ | Level interrupt lines from peripherals |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | ADDR_W | Word address: bank index above, word offset below |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous address |
| irq_out | output | NUM_CPU | One interrupt line per CPU |

## Verification
The assertions assume that irq_in and the port inputs are synchronous to clk and change only between edges. They also assume the port carries at most one access per cycle, so one bank never sees a set and a clear at the same edge. The bench drives every input on the falling edge and issues one write or one read per task. This keeps the stimulus inside those limits while it covers write-one masking, reads of set and clear words, writes to read-only and unmapped offsets, and the one-cycle lag of each CPU line.

// File: rtl/irq_l1_pkg.sv
package irq_l1_pkg;

    localparam int GROUP_BITS = 32;

    typedef logic [GROUP_BITS-1:0] word_t;

    // Region of a bank offset; the order fixes the bank layout.
    typedef enum logic [2:0] {
        RG_STATUS = 3'd0,
        RG_MASK   = 3'd1,
        RG_SET    = 3'd2,
        RG_CLR    = 3'd3,
        RG_NONE   = 3'd4
    } region_e;

    function automatic int unsigned bits_for(input int unsigned n);
        int unsigned b;
        b = 1;
        while ((1 << b) < n) b++;
        return b;
    endfunction

    function automatic region_e region_of(input int unsigned off, input int unsigned words);
        if (off < words)          return RG_STATUS;
        else if (off < 2 * words) return RG_MASK;
        else if (off < 3 * words) return RG_SET;
        else if (off < 4 * words) return RG_CLR;
        return RG_NONE;
    endfunction

    function automatic int unsigned word_of(input int unsigned off, input int unsigned words);
        return off % words;
    endfunction

endpackage

// File: rtl/irq_l1_decode.sv
module irq_l1_decode
    import irq_l1_pkg::*;
#(
    parameter int NUM_CPU = 2,
    parameter int WORDS   = 3,
    parameter int CPU_W   = 1,
    parameter int OFF_W   = 4,
    parameter int WIX_W   = 2
) (
    input  logic                   bus_wr,
    input  logic [CPU_W+OFF_W-1:0] bus_addr,
    output region_e                region,
    output logic [WIX_W-1:0]       word_idx,
    output logic [CPU_W-1:0]       cpu_idx,
    output logic                   cpu_ok,
    output logic [NUM_CPU-1:0]     set_en,
    output logic [NUM_CPU-1:0]     clr_en
);
    logic [OFF_W-1:0] off;

    always_comb begin
        off      = bus_addr[OFF_W-1:0];
        cpu_idx  = bus_addr[CPU_W+OFF_W-1:OFF_W];
        cpu_ok   = int'(cpu_idx) < NUM_CPU;
        region   = region_of(32'(off), WORDS);
        word_idx = WIX_W'(word_of(32'(off), WORDS));
    end

    // One write-enable per bank; out-of-range banks match none (R10).
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_en
        always_comb begin
            set_en[c] = bus_wr && cpu_ok && (int'(cpu_idx) == c) && (region == RG_SET);
            clr_en[c] = bus_wr && cpu_ok && (int'(cpu_idx) == c) && (region == RG_CLR);
        end
    end

endmodule

// File: rtl/irq_l1_mask_bank.sv
module irq_l1_mask_bank
    import irq_l1_pkg::*;
#(
    parameter int NUM_IRQ = 96,
    parameter int WORDS   = 3,
    parameter int WIX_W   = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic               set_en,
    input  logic               clr_en,
    input  logic [WIX_W-1:0]   word_idx,
    input  word_t              wdata,
    output logic [NUM_IRQ-1:0] mask_q,
    output logic               irq_out
);
    logic [WORDS-1:0][GROUP_BITS-1:0] mask_w;
    logic [WORDS-1:0][GROUP_BITS-1:0] mask_d;
    logic [WORDS-1:0]                 pend_w;

    assign mask_q = mask_w;

    for (genvar k = 0; k < WORDS; k++) begin : g_word
        word_t set_bits;
        word_t clr_bits;
        always_comb begin
            set_bits  = (set_en && int'(word_idx) == k) ? wdata : '0;
            clr_bits  = (clr_en && int'(word_idx) == k) ? wdata : '0;
            // Clear beats set on the same bit.
            mask_d[k] = (mask_w[k] | set_bits) & ~clr_bits;
            pend_w[k] = |(irq_in[k*GROUP_BITS +: GROUP_BITS] & ~mask_w[k]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_w  <= '1;
            irq_out <= 1'b0;
        end else begin
            mask_w  <= mask_d;
            irq_out <= |pend_w;
        end
    end

endmodule

// File: rtl/irq_l1_rdmux.sv
module irq_l1_rdmux
    import irq_l1_pkg::*;
#(
    parameter int NUM_IRQ = 96,
    parameter int NUM_CPU = 2,
    parameter int WORDS   = 3,
    parameter int CPU_W   = 1,
    parameter int WIX_W   = 2
) (
    input  logic                                           clk,
    input  logic                                           rst,
    input  logic [NUM_IRQ-1:0]                             irq_in,
    input  logic [NUM_CPU-1:0][WORDS-1:0][GROUP_BITS-1:0] mask_words,
    input  region_e                                        region,
    input  logic [WIX_W-1:0]                               word_idx,
    input  logic [CPU_W-1:0]                               cpu_idx,
    input  logic                                           cpu_ok,
    output word_t                                          rdata
);
    logic [WORDS-1:0][GROUP_BITS-1:0] in_words;
    word_t                            rd_d;

    assign in_words = irq_in;

    always_comb begin
        rd_d = '0;
        if (cpu_ok) begin
            unique case (region)
                RG_STATUS: rd_d = in_words[word_idx];
                RG_MASK:   rd_d = mask_words[cpu_idx][word_idx];
                default:   rd_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else     rdata <= rd_d;
    end

endmodule

// File: rtl/irq_l1_aggregator.sv
module irq_l1_aggregator
    import irq_l1_pkg::*;
#(
    parameter int NUM_IRQ = 96,
    parameter int NUM_CPU = 2,
    localparam int WORDS  = NUM_IRQ / GROUP_BITS,
    localparam int OFF_W  = bits_for(4 * WORDS),
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int ADDR_W = CPU_W + OFF_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [NUM_CPU-1:0] irq_out
);
    localparam int WIX_W = $clog2(WORDS);

    region_e                       region;
    logic [WIX_W-1:0]              word_idx;
    logic [CPU_W-1:0]              cpu_idx;
    logic                          cpu_ok;
    logic [NUM_CPU-1:0]            set_en;
    logic [NUM_CPU-1:0]            clr_en;
    logic [NUM_CPU-1:0][NUM_IRQ-1:0] mask_all;

    irq_l1_decode #(
        .NUM_CPU(NUM_CPU), .WORDS(WORDS), .CPU_W(CPU_W), .OFF_W(OFF_W), .WIX_W(WIX_W)
    ) i_decode (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .region   (region),
        .word_idx (word_idx),
        .cpu_idx  (cpu_idx),
        .cpu_ok   (cpu_ok),
        .set_en   (set_en),
        .clr_en   (clr_en)
    );

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_bank
        irq_l1_mask_bank #(
            .NUM_IRQ(NUM_IRQ), .WORDS(WORDS), .WIX_W(WIX_W)
        ) i_bank (
            .clk      (clk),
            .rst      (rst),
            .irq_in   (irq_in),
            .set_en   (set_en[c]),
            .clr_en   (clr_en[c]),
            .word_idx (word_idx),
            .wdata    (bus_wdata),
            .mask_q   (mask_all[c]),
            .irq_out  (irq_out[c])
        );
    end

    irq_l1_rdmux #(
        .NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .WORDS(WORDS), .CPU_W(CPU_W), .WIX_W(WIX_W)
    ) i_rdmux (
        .clk        (clk),
        .rst        (rst),
        .irq_in     (irq_in),
        .mask_words (mask_all),
        .region     (region),
        .word_idx   (word_idx),
        .cpu_idx    (cpu_idx),
        .cpu_ok     (cpu_ok),
        .rdata      (bus_rdata)
    );

endmodule

// File: rtl/irq_l1_checker.sv
module irq_l1_checker
    import irq_l1_pkg::*;
#(
    parameter int NUM_IRQ = 96,
    parameter int NUM_CPU = 2,
    parameter int OFF_W   = 4,
    parameter int CPU_W   = 1
) (
    input logic                            clk,
    input logic                            rst,
    input logic [NUM_IRQ-1:0]              irq_in,
    input logic                            bus_wr,
    input logic [CPU_W+OFF_W-1:0]          bus_addr,
    input logic [31:0]                     bus_wdata,
    input logic [31:0]                     bus_rdata,
    input logic [NUM_CPU-1:0]              irq_out,
    input logic [NUM_CPU-1:0][NUM_IRQ-1:0] mask_all
);
    localparam int WORDS = NUM_IRQ / GROUP_BITS;

    region_e     rg;
    int unsigned wix;
    int unsigned cpu;

    always_comb begin
        rg  = region_of(32'(bus_addr[OFF_W-1:0]), WORDS);
        wix = word_of(32'(bus_addr[OFF_W-1:0]), WORDS);
        cpu = 32'(bus_addr[CPU_W+OFF_W-1:OFF_W]);
    end

    // R6, R10: set/clear words and unmapped offsets read back zero.
    p_rd_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (rg == RG_SET || rg == RG_CLR || rg == RG_NONE) |=> bus_rdata == 32'h0);

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        // R1: reset leaves everything masked and the line low.
        p_reset_masked_r1: assert property (@(posedge clk)
            rst |=> (&mask_all[c]) && !irq_out[c]);

        // R7: registered OR of unmasked live inputs.
        p_out_follows_r7: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> irq_out[c] == |($past(irq_in) & ~$past(mask_all[c])));

        // R6, R8, R10: only a set/clear write aimed at this bank changes its mask.
        p_mask_hold_r8: assert property (@(posedge clk) disable iff (rst)
            !(bus_wr && cpu == c && (rg == RG_SET || rg == RG_CLR))
            |=> $stable(mask_all[c]));

        for (genvar k = 0; k < WORDS; k++) begin : g_word
            // R4
            p_set_bits_r4: assert property (@(posedge clk) disable iff (rst)
                (bus_wr && cpu == c && rg == RG_SET && wix == k)
                |=> (mask_all[c][k*32 +: 32] & $past(bus_wdata)) == $past(bus_wdata));
            // R5
            p_clr_bits_r5: assert property (@(posedge clk) disable iff (rst)
                (bus_wr && cpu == c && rg == RG_CLR && wix == k)
                |=> (mask_all[c][k*32 +: 32] & $past(bus_wdata)) == 32'h0);
        end
    end

endmodule

bind irq_l1_aggregator irq_l1_checker #(
    .NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .OFF_W(OFF_W), .CPU_W(CPU_W)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .irq_in    (irq_in),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .mask_all  (mask_all)
);

// File: tb/test_irq_l1_aggregator.sv
module test_irq_l1_aggregator;
    localparam int NIRQ = 96;
    localparam int NCPU = 2;
    localparam int W    = 3;   // status 0..2, mask 3..5, set 6..8, clr 9..11

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NIRQ-1:0] irq_in = '0;
    logic            bus_wr = 1'b0;
    logic [4:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NCPU-1:0] irq_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [NIRQ-1:0] mdl [NCPU];

    always #5 clk = ~clk;

    irq_l1_aggregator #(.NUM_IRQ(NIRQ), .NUM_CPU(NCPU)) i_irq_l1_aggregator (
        .clk(clk), .rst(rst), .irq_in(irq_in), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input int cpu, input int off, input logic [31:0] d);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = 5'(cpu * 16 + off);
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
        if (cpu < NCPU && off >= 2*W && off < 3*W) mdl[cpu][(off-2*W)*32 +: 32] |= d;
        if (cpu < NCPU && off >= 3*W && off < 4*W) mdl[cpu][(off-3*W)*32 +: 32] &= ~d;
    endtask

    task automatic rd(input int cpu, input int off, output logic [31:0] d);
        @(negedge clk);
        bus_addr = 5'(cpu * 16 + off);
        @(negedge clk);
        d = bus_rdata;
    endtask

    function automatic logic [NCPU-1:0] exp_out();
        logic [NCPU-1:0] e;
        for (int c = 0; c < NCPU; c++) e[c] = |(irq_in & ~mdl[c]);
        return e;
    endfunction

    task automatic check_masks(input string req);
        logic [31:0] d;
        for (int c = 0; c < NCPU; c++)
            for (int k = 0; k < W; k++) begin
                rd(c, W + k, d);
                check(req, d, mdl[c][k*32 +: 32]);
            end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        irq_in = '1;
        @(negedge clk);
        check("R1 out during reset", 32'(irq_out), 32'h0);
        @(negedge clk);
        rst = 1'b0;
        check("R1 out after reset", 32'(irq_out), 32'h0);
        check_masks("R1 R3 reset masks");
        check("R1 out still low", 32'(irq_out), 32'h0);
        rd(0, 2*W, d);
        check("R6 set word reads zero", d, 32'h0);
        irq_in = '0;
    endtask

    task automatic t_status();
        logic [31:0] d;
        logic [NIRQ-1:0] pats [3];
        pats[0] = {32'hDEAD_BEEF, 32'h0123_4567, 32'h89AB_CDEF};
        pats[1] = {32'h8000_0001, 32'h0, 32'hFFFF_FFFF};
        pats[2] = {32'h0, 32'h5555_AAAA, 32'h0000_0001};
        for (int p = 0; p < 3; p++) begin
            irq_in = pats[p];
            for (int c = 0; c < NCPU; c++)
                for (int k = 0; k < W; k++) begin
                    rd(c, k, d);
                    check("R2 status word", d, pats[p][k*32 +: 32]);
                end
        end
        irq_in = '0;
    endtask

    task automatic t_set_clear();
        logic [31:0] d;
        wr(0, 3*W + 1, 32'h0000_00F0);
        rd(0, W + 1, d);
        check("R5 clear", d, 32'hFFFF_FF0F);
        wr(0, 2*W + 1, 32'h0000_0030);
        rd(0, W + 1, d);
        check("R4 set", d, 32'hFFFF_FF3F);
        wr(0, 3*W + 1, 32'h0);
        rd(0, W + 1, d);
        check("R5 zero clear keeps", d, 32'hFFFF_FF3F);
        wr(0, 2*W + 1, 32'h0);
        rd(0, W + 1, d);
        check("R4 zero set keeps", d, 32'hFFFF_FF3F);
        rd(0, 3*W + 1, d);
        check("R6 clear word reads zero", d, 32'h0);
    endtask

    task automatic t_output();
        wr(0, 3*W + 2, 32'h0000_0020);  // unmask input 69 on bank 0
        @(negedge clk);
        check("R7 idle", 32'(irq_out), 32'h0);
        irq_in[69] = 1'b1;
        #1;
        check("R7 not before edge", 32'(irq_out), 32'h0);
        @(negedge clk);
        check("R7 one cycle later", 32'(irq_out), 32'h1);
        irq_in[69] = 1'b0;
        @(negedge clk);
        check("R9 level drop", 32'(irq_out), 32'h0);
        irq_in[69] = 1'b1;
        @(negedge clk);
        wr(0, 2*W + 2, 32'h0000_0020);  // remask
        check("R7 old mask still seen", 32'(irq_out), 32'h1);
        @(negedge clk);
        check("R7 remask lowers", 32'(irq_out), 32'h0);
        irq_in = '0;
    endtask

    task automatic t_independent();
        wr(1, 3*W + 0, 32'h0000_0001);
        check_masks("R8 bank masks");
        irq_in[0] = 1'b1;
        @(negedge clk);
        check("R8 only bank 1", 32'(irq_out), 32'h2);
        irq_in = '0;
        @(negedge clk);
    endtask

    task automatic t_readonly();
        wr(1, 0, 32'hFFFF_FFFF);
        wr(1, W + 0, 32'hFFFF_FFFF);
        wr(0, W + 1, 32'h0);
        check_masks("R6 read-only writes ignored");
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        for (int off = 4*W; off < 16; off++) wr(0, off, 32'hFFFF_FFFF);
        for (int off = 4*W; off < 16; off++) begin
            rd(0, off, d);
            check("R10 unmapped reads zero", d, 32'h0);
        end
        check_masks("R10 unmapped writes ignored");
        irq_in = '1;
        @(negedge clk);
        @(negedge clk);
        check("R10 outputs follow model", 32'(irq_out), 32'(exp_out()));
        irq_in = '0;
    endtask

    initial begin
        for (int c = 0; c < NCPU; c++) mdl[c] = '1;
        t_reset();
        t_status();
        t_set_clear();
        t_output();
        t_independent();
        t_readonly();
        t_unmapped();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule